// File: doc/BRIEF.md
# Word-Wide Memory Bus Subsystem

This block sits on the bus of a 16-bit processor. It holds a read-only region and a small read/write region. Each region is built from two byte-wide arrays. One array feeds the upper data byte and the other feeds the lower data byte, so every access moves a whole 16-bit word. The processor marks a cycle with an active-low memory-enable strobe. A data-bus-in level says which side may drive the data lines, and an active-low write strobe marks a store. The block decodes the word address, picks a region and drives read data only while the processor has released the bus. It stores write data into the read/write region on the clock edge.

The data bus is split into a write-data input, a read-data output and a read-drive enable. The enable stands in for the tri-state control of a shared bus. While the enable is low, the read data is held at zero. The read-only contents come from a computed pattern, selected by a seed parameter, so no content file is involved. Reads are combinational from the address and strobes. Writes take effect at the rising clock edge.

Top module: `word_mem_subsys`

## Requirements
- R1: With memory-enable low, data-bus-in high and write strobe high, region select `bus_addr[14:12]` = 000 reads the ROM word at index `bus_addr[11:0]` in the same cycle. The upper byte is `idx[11:4] ^ SEED[15:8]` and the lower byte is `idx[7:0] ^ SEED[7:0]`. SEED defaults to 16'hA55A. Address bit `bus_addr[14]` is the most significant address line and `bus_addr[0]` the least significant word-address line.
- R2: Region select 100 reaches the RAM word at index `bus_addr[6:0]`. Bits `bus_addr[11:7]` are ignored, so the 128 words alias across them.
- R3: `rdata_oe` is 1 exactly when memory-enable is low, data-bus-in is high, the write strobe is high, reset is released and the region select is 000 or 100.
- R4: While data-bus-in is low, `rdata_oe` is 0 and `rdata` is 16'h0000.
- R5: With memory-enable low, data-bus-in low and write strobe low in the RAM region, the full `wdata` word is stored at the rising clock edge. The next read of that index returns it.
- R6: A write cycle in the ROM region changes no RAM word, and ROM reads still return the pattern.
- R7: Region selects other than 000 and 100 never drive the bus, and writes to them change no RAM word.
- R8: While memory-enable is high, `rdata_oe` is 0 and no RAM word changes, whatever the other strobes do.
- R9: Reset (`rst_n` low) clears every RAM word to 16'h0000 and holds `rdata_oe` at 0.
- R10: A write changes only the addressed RAM word. Both byte lanes are updated together and neighbouring words keep their values.
- R11: A cycle with the write strobe low while data-bus-in is high neither drives the bus nor stores data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; RAM stores on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_en_n | input | 1 | Memory-enable strobe, active low |
| dbin | input | 1 | Data-bus-in: high when the processor has released the data lines |
| we_n | input | 1 | Write strobe, active low |
| bus_addr | input | 15 | Word address; bit 14 is the most significant line |
| wdata | input | 16 | Write data from the processor |
| rdata | output | 16 | Read data; zero when not driving |
| rdata_oe | output | 1 | Read-drive enable for both data byte lanes |

## Verification
Two functions can share a cycle. A RAM store happens at one clock edge, and a read of the same word can follow in the very next cycle, which tests whether the stored word is visible at once. The bench provokes this by issuing a read straight after each write without an idle cycle between them, and it compares the read with the word it wrote. The second case is a conflicting cycle, where the write strobe is low while data-bus-in is high. The bench drives it to a RAM word and then reads that word back, and the check is that nothing was driven and the old value remains.

// File: rtl/wms_pkg.sv
package wms_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_ROM  = 2'd1,
    REG_RAM  = 2'd2
  } region_e;

  // Pattern byte for one ROM lane: shift the index by four bits per lane, mix in the seed byte.
  function automatic logic [31:0] rom_pattern(input logic [31:0] idx, input int lane,
                                              input logic [31:0] seed);
    logic [31:0] shifted;
    logic [31:0] key;
    shifted = idx >> (lane * 4);
    key     = seed >> (lane * 8);
    return (shifted ^ key) & 32'h0000_00FF;
  endfunction

  function automatic region_e region_of(input logic [SEL_W-1:0] sel,
                                        input logic [SEL_W-1:0] rom_code,
                                        input logic [SEL_W-1:0] ram_code);
    if (sel == rom_code)      return REG_ROM;
    else if (sel == ram_code) return REG_RAM;
    else                      return REG_NONE;
  endfunction

endpackage

// File: rtl/wms_decode.sv
module wms_decode
  import wms_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int ROM_IDX_W = 12,
  parameter int RAM_IDX_W = 7,
  parameter logic [SEL_W-1:0] ROM_CODE = 3'b000,
  parameter logic [SEL_W-1:0] RAM_CODE = 3'b100
) (
  input  logic                 rst_n,
  input  logic                 mem_en_n,
  input  logic                 dbin,
  input  logic                 we_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic                 sel_rom,
  output logic                 sel_ram,
  output logic                 rd_cycle,
  output logic                 wr_cycle,
  output logic [ROM_IDX_W-1:0] rom_idx,
  output logic [RAM_IDX_W-1:0] ram_idx
);
  localparam int SEL_LSB = ADDR_W - SEL_W;

  region_e region;

  always_comb begin
    region   = region_of(bus_addr[ADDR_W-1:SEL_LSB], ROM_CODE, RAM_CODE);
    sel_rom  = (region == REG_ROM);
    sel_ram  = (region == REG_RAM);
    rd_cycle = rst_n && !mem_en_n && dbin && we_n;
    wr_cycle = rst_n && !mem_en_n && !dbin && !we_n;
    rom_idx  = bus_addr[ROM_IDX_W-1:0];
    ram_idx  = bus_addr[RAM_IDX_W-1:0];
  end

endmodule

// File: rtl/wms_rom_lane.sv
module wms_rom_lane
  import wms_pkg::*;
#(
  parameter int          IDX_W  = 12,
  parameter int          LANE_W = 8,
  parameter int          LANE   = 0,
  parameter logic [31:0] SEED   = 32'h0000_A55A
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [LANE_W-1:0] rbyte
);
  logic [31:0] pattern;

  always_comb begin
    pattern = rom_pattern(32'(idx), LANE, SEED);
    rbyte   = pattern[LANE_W-1:0];
  end

endmodule

// File: rtl/wms_ram_lane.sv
module wms_ram_lane #(
  parameter int IDX_W  = 7,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wbyte,
  output logic [LANE_W-1:0] rbyte
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[idx] <= wbyte;
    end
  end

  assign rbyte = cells[idx];

endmodule

// File: rtl/word_mem_subsys.sv
module word_mem_subsys
  import wms_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter int ROM_IDX_W = 12,
  parameter int RAM_IDX_W = 7,
  parameter logic [SEL_W-1:0] ROM_CODE = 3'b000,
  parameter logic [SEL_W-1:0] RAM_CODE = 3'b100,
  parameter logic [DATA_W-1:0] SEED    = 16'hA55A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en_n,
  input  logic              dbin,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam int LANES = DATA_W / LANE_W;

  // Named internal events, visible to the bound checker.
  logic                 sel_rom;
  logic                 sel_ram;
  logic                 rd_cycle;
  logic                 wr_cycle;
  logic                 ram_we;
  logic [ROM_IDX_W-1:0] rom_idx;
  logic [RAM_IDX_W-1:0] ram_idx;
  logic [DATA_W-1:0]    rom_word;
  logic [DATA_W-1:0]    ram_word;

  wms_decode #(
    .ADDR_W(ADDR_W), .ROM_IDX_W(ROM_IDX_W), .RAM_IDX_W(RAM_IDX_W),
    .ROM_CODE(ROM_CODE), .RAM_CODE(RAM_CODE)
  ) u_decode (
    .rst_n(rst_n), .mem_en_n(mem_en_n), .dbin(dbin), .we_n(we_n),
    .bus_addr(bus_addr), .sel_rom(sel_rom), .sel_ram(sel_ram),
    .rd_cycle(rd_cycle), .wr_cycle(wr_cycle),
    .rom_idx(rom_idx), .ram_idx(ram_idx)
  );

  assign ram_we = wr_cycle && sel_ram;

  // One byte-wide array per data lane; lane 0 is the lower byte.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wms_rom_lane #(
      .IDX_W(ROM_IDX_W), .LANE_W(LANE_W), .LANE(g), .SEED(32'(SEED))
    ) u_rom (
      .idx(rom_idx), .rbyte(rom_word[g*LANE_W +: LANE_W])
    );

    wms_ram_lane #(.IDX_W(RAM_IDX_W), .LANE_W(LANE_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx),
      .wbyte(wdata[g*LANE_W +: LANE_W]),
      .rbyte(ram_word[g*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    rdata_oe = rd_cycle && (sel_rom || sel_ram);
    if (!rdata_oe)    rdata = '0;
    else if (sel_rom) rdata = rom_word;
    else              rdata = ram_word;
  end

endmodule

// File: rtl/word_mem_subsys_chk.sv
module word_mem_subsys_chk #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int RAM_IDX_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en_n,
  input logic              dbin,
  input logic              we_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe,
  input logic              ram_we
);
  logic [2:0] sel;
  logic       in_map;
  logic       in_ram;
  logic       plain_read;

  assign sel        = bus_addr[ADDR_W-1:ADDR_W-3];
  assign in_map     = (sel == 3'b000) || (sel == 3'b100);
  assign in_ram     = (sel == 3'b100);
  assign plain_read = !mem_en_n && dbin && we_n;

  assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_read && in_map) |-> rdata_oe);

  assert_no_drive_dbin_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dbin |-> (!rdata_oe && rdata == '0));

  assert_write_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ram_we) && plain_read && in_ram &&
     bus_addr[RAM_IDX_W-1:0] == $past(bus_addr[RAM_IDX_W-1:0])) |-> rdata == $past(wdata));

  assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_map |-> (!rdata_oe && !ram_we));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_n |-> (!rdata_oe && !ram_we));

  assert_ram_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_read && in_ram && $past(plain_read && in_ram && !ram_we) &&
     $stable(bus_addr)) |-> $stable(rdata));

  assert_conflict_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbin && !we_n) |-> (!rdata_oe && !ram_we));

endmodule

bind word_mem_subsys word_mem_subsys_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_IDX_W(RAM_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_en_n(mem_en_n), .dbin(dbin), .we_n(we_n),
  .bus_addr(bus_addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
  .ram_we(ram_we)
);

// File: tb/word_mem_subsys_tb.sv
`timescale 1ns/1ps
module word_mem_subsys_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_en_n = 1'b1;
  logic        dbin = 1'b1;
  logic        we_n = 1'b1;
  logic [14:0] bus_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  word_mem_subsys u_dut (
    .clk(clk), .rst_n(rst_n), .mem_en_n(mem_en_n), .dbin(dbin), .we_n(we_n),
    .bus_addr(bus_addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // ROM model restated: upper byte from index bits 11..4, lower from 7..0, each xored with the seed byte.
  function automatic logic [15:0] rom_exp(input logic [11:0] idx);
    logic [7:0] hi, lo;
    hi = idx[11:4] ^ 8'hA5;
    lo = idx[7:0]  ^ 8'h5A;
    return {hi, lo};
  endfunction

  function automatic logic [14:0] ram_a(input logic [4:0] alias_bits, input logic [6:0] idx);
    return {3'b100, alias_bits, idx};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_bus(input logic en_n, input logic din, input logic wn,
                         input logic [14:0] a, input logic [15:0] d);
    @(negedge clk);
    mem_en_n = en_n; dbin = din; we_n = wn; bus_addr = a; wdata = d;
  endtask

  task automatic rd(input logic [14:0] a, output logic [15:0] d, output logic oe);
    set_bus(1'b0, 1'b1, 1'b1, a, 16'h0);
    #1;
    d = rdata; oe = rdata_oe;
  endtask

  task automatic wr(input logic [14:0] a, input logic [15:0] d);
    set_bus(1'b0, 1'b0, 1'b0, a, d);
  endtask

  task automatic idle();
    set_bus(1'b1, 1'b1, 1'b1, 15'h0, 16'h0);
  endtask

  task automatic t_reset();
    logic [15:0] d; logic oe;
    #1;
    chk("R9 oe in reset", {15'h0, rdata_oe}, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(ram_a(5'd0, 7'd5), d, oe);
    chk("R9 ram cleared", d, 16'h0000);
    rd(ram_a(5'd0, 7'd127), d, oe);
    chk("R9 ram top cleared", d, 16'h0000);
  endtask

  task automatic t_rom_reads();
    logic [15:0] d; logic oe;
    rd({3'b000, 12'h000}, d, oe);
    chk("R1 rom idx 000", d, rom_exp(12'h000));
    chk("R3 oe rom", {15'h0, oe}, 16'h1);
    rd({3'b000, 12'hFFF}, d, oe);
    chk("R1 rom idx FFF", d, rom_exp(12'hFFF));
    rd({3'b000, 12'h123}, d, oe);
    chk("R1 rom idx 123", d, rom_exp(12'h123));
  endtask

  task automatic t_ram_rw();
    logic [15:0] d; logic oe;
    wr(ram_a(5'd0, 7'd3), 16'h1234);
    rd(ram_a(5'd0, 7'd3), d, oe);
    chk("R5 ram idx 3", d, 16'h1234);
    chk("R3 oe ram", {15'h0, oe}, 16'h1);
    wr(ram_a(5'd0, 7'd127), 16'hBEEF);
    rd(ram_a(5'd0, 7'd127), d, oe);
    chk("R5 ram idx 127", d, 16'hBEEF);
    rd(ram_a(5'd0, 7'd4), d, oe);
    chk("R10 neighbour 4", d, 16'h0000);
    rd(ram_a(5'd0, 7'd2), d, oe);
    chk("R10 neighbour 2", d, 16'h0000);
  endtask

  task automatic t_alias();
    logic [15:0] d; logic oe;
    rd(ram_a(5'b10101, 7'd3), d, oe);
    chk("R2 alias read", d, 16'h1234);
    wr(ram_a(5'b11111, 7'd9), 16'hC3A5);
    rd(ram_a(5'd0, 7'd9), d, oe);
    chk("R2 alias write", d, 16'hC3A5);
  endtask

  task automatic t_dbin_low();
    set_bus(1'b0, 1'b0, 1'b1, ram_a(5'd0, 7'd3), 16'h0);
    #1;
    chk("R4 oe dbin low", {15'h0, rdata_oe}, 16'h0);
    chk("R4 rdata dbin low", rdata, 16'h0000);
  endtask

  task automatic t_rom_write();
    logic [15:0] d; logic oe;
    wr({3'b000, 12'h003}, 16'hDEAD);
    rd({3'b000, 12'h003}, d, oe);
    chk("R6 rom unchanged", d, rom_exp(12'h003));
    rd(ram_a(5'd0, 7'd3), d, oe);
    chk("R6 ram unchanged", d, 16'h1234);
  endtask

  task automatic t_unmapped();
    logic [15:0] d; logic oe;
    rd({3'b010, 12'h003}, d, oe);
    chk("R7 no drive", {15'h0, oe}, 16'h0);
    chk("R7 rdata zero", d, 16'h0000);
    wr({3'b110, 12'h003}, 16'h5555);
    rd(ram_a(5'd0, 7'd3), d, oe);
    chk("R7 ram unchanged", d, 16'h1234);
  endtask

  task automatic t_idle();
    logic [15:0] d; logic oe;
    set_bus(1'b1, 1'b1, 1'b1, ram_a(5'd0, 7'd3), 16'h0);
    #1;
    chk("R8 oe idle", {15'h0, rdata_oe}, 16'h0);
    set_bus(1'b1, 1'b0, 1'b0, ram_a(5'd0, 7'd3), 16'h7777);
    rd(ram_a(5'd0, 7'd3), d, oe);
    chk("R8 ram unchanged", d, 16'h1234);
  endtask

  task automatic t_conflict();
    logic [15:0] d; logic oe;
    set_bus(1'b0, 1'b1, 1'b0, ram_a(5'd0, 7'd3), 16'h9999);
    #1;
    chk("R11 oe conflict", {15'h0, rdata_oe}, 16'h0);
    rd(ram_a(5'd0, 7'd3), d, oe);
    chk("R11 ram unchanged", d, 16'h1234);
  endtask

  task automatic t_reset_again();
    logic [15:0] d; logic oe;
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(ram_a(5'd0, 7'd3), d, oe);
    chk("R9 cleared again", d, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_rom_reads();
    t_ram_rw();
    t_alias();
    t_dbin_low();
    t_rom_write();
    t_unmapped();
    t_idle();
    t_conflict();
    t_reset_again();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule